// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block runs every pin-level transaction needed to read or write one word of a 64 x 16 three-wire serial EEPROM. It drives chip select, the serial clock and the serial data line toward the memory, and samples the memory's data-out line. A request names the operation (read or write), a 6-bit word address and, for writes, a 16-bit value. The block returns the word that was read, a one-cycle completion pulse and a flag that reports when a write never signalled completion.

Every pin change is a step, and each step lasts exactly `PHASE_CYC` system clocks. A read selects the memory, sends its opcode and address, clocks in 16 bits and finishes with a standby toggle. The chip stays selected after a read. A write is wrapped automatically:

1. An enable command padded to 9 bits.
2. A standby toggle.
3. The write command, address and data.
4. A standby toggle that starts the internal program cycle.
5. A busy poll on data-out, limited to `POLL_MAX` windows.
6. A recovery standby.
7. A disable command padded to 9 bits.
8. A final deselect with one clock pulse.

The states are IDLE, SETUP_LO, SETUP_CS, TX_SET, TX_HI, TX_LO, TX_END, RX_HI, RX_LO, SB_DROP, SB_SKHI, SB_CSHI, SB_SKLO, POLL, CL_DROP, CL_SKHI, CL_SKLO and FINISH. Each timed state moves on when its phase window ends.

- IDLE goes to SETUP_LO when a request arrives.
- SETUP_LO goes to SETUP_CS, and SETUP_CS goes to TX_SET.
- The bit loop runs TX_SET, TX_HI, TX_LO. It returns to TX_SET until the last bit, then goes to TX_END.
- TX_END goes to RX_HI for a read. It goes to SB_DROP after the enable or write command. It goes to CL_DROP after the disable command.
- The receive loop runs RX_HI, RX_LO. After 16 bits it goes to SB_DROP.
- The standby chain runs SB_DROP, SB_SKHI, SB_CSHI, SB_SKLO. It then continues to TX_SET (to send the write or disable command), to POLL (after the write) or to FINISH (after a read).
- POLL goes to SB_DROP on a high sample or when its count is used up. Otherwise it stays in POLL.
- The cleanup runs CL_DROP, CL_SKHI, CL_SKLO, then FINISH.
- FINISH goes to IDLE after one clock.

Top module: `uw_eeprom_master`

## Requirements
- R1: After reset ee_cs, ee_sk, ee_di, busy, done and timeout are low and rd_data is zero. Whenever busy is low, ee_sk and ee_di are low.
- R2: A command starts with one phase in which ee_sk and ee_di are low and ee_cs keeps its idle level, followed by one phase with ee_cs high. Every step in every sequence lasts exactly PHASE_CYC clocks.
- R3: Each transmitted bit, MSB first, is one phase with ee_di at the bit and ee_sk low, then one phase with ee_sk high, then one phase with ee_sk low. After the last bit of a command, ee_di is low for one phase. ee_di never changes while ee_sk is high.
- R4: A read sends 3'b110 and then the 6 address bits MSB first. It then gives 16 clock pulses with ee_di low, sampling ee_do on the last clock of each high phase, MSB first. The assembled word appears on rd_data in the done cycle.
- R5: A standby is four phases with (ee_cs, ee_sk) = (0,0), (0,1), (1,1), (1,0). A read ends with one standby, and ee_cs stays high while idle afterwards.
- R6: A write first sends 5'b10011 followed by four 0 bits, then a standby, then 3'b101, the 6 address bits and the 16 data bits MSB first, then a standby.
- R7: After the write standby, the block holds ee_cs high and ee_sk low in windows of one phase each. It samples ee_do on the last clock of each window. The first high sample ends the poll.
- R8: If POLL_MAX samples in a row are low, the sequence continues as if complete, and timeout is high from the done cycle until the next accepted request. A write that completes in time reports timeout low.
- R9: After the poll the block issues a standby, then sends 5'b10000 followed by four 0 bits. It then drives one phase with ee_cs and ee_di low, one phase with ee_sk high and one phase with ee_sk low. ee_cs stays low while idle afterwards.
- R10: done is high for exactly the one clock after the last phase. busy is high from the clock after acceptance through the done clock.
- R11: A request while busy is high is ignored and does not alter the running sequence.
- R12: rd_data changes only in a read's done cycle and holds across later writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Last word read |
| timeout | output | 1 | Last write saw no completion in the poll |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
A request sampled at clock edge E0 shows its first step on the pins in the cycle that starts at E0. Each later step follows exactly PHASE_CYC cycles after the previous one, and done, rd_data and timeout are updated in the one cycle after the final step. The bench expands each accepted request into a per-cycle queue of expected pin levels, busy, done and the ee_do value to drive, and pops one entry on every falling edge. A wrong step length, bit order, sample point or poll count therefore shows up in the first cycle where it differs. The memory's data-out is driven from the same queue, so read bits and the end of the busy poll line up exactly with the sampling edge of the window they belong to.

// File: rtl/uw_pkg.sv
`timescale 1ns/1ps
package uw_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam int CMD_W     = 3 + ADDR_W + DATA_W;
    localparam int CMD_LEN_W = $clog2(CMD_W + 1);
    localparam int PAD_W     = 4;
    localparam int CTL_LEN   = 5 + PAD_W;
    localparam int RD_LEN    = 3 + ADDR_W;

    localparam logic [2:0] OP_READ  = 3'b110;
    localparam logic [2:0] OP_WRITE = 3'b101;
    localparam logic [4:0] OP_WEN   = 5'b10011;
    localparam logic [4:0] OP_WDIS  = 5'b10000;

    typedef enum logic [4:0] {
        ST_IDLE, ST_SETUP_LO, ST_SETUP_CS,
        ST_TX_SET, ST_TX_HI, ST_TX_LO, ST_TX_END,
        ST_RX_HI, ST_RX_LO,
        ST_SB_DROP, ST_SB_SKHI, ST_SB_CSHI, ST_SB_SKLO,
        ST_POLL,
        ST_CL_DROP, ST_CL_SKHI, ST_CL_SKLO,
        ST_FINISH
    } uw_state_t;

    typedef enum logic [2:0] {
        SEG_RD, SEG_EN, SEG_WR, SEG_WAIT, SEG_RECOVER, SEG_DIS
    } uw_seg_t;
endpackage

// File: rtl/uw_phase_timer.sv
`timescale 1ns/1ps
module uw_phase_timer #(
    parameter int PHASE_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = !restart && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (restart || expire) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uw_bit_shifter.sv
`timescale 1ns/1ps
module uw_bit_shifter #(
    parameter int TX_W  = 25,
    parameter int RX_W  = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TX_W-1:0]  load_word,
    input  logic [LEN_W-1:0] load_len,
    input  logic             tx_adv,
    input  logic             rx_adv,
    input  logic             rx_bit,
    output logic             tx_bit,
    output logic             last_bit,
    output logic             empty,
    output logic [RX_W-1:0]  rx_word
);
    logic [TX_W-1:0]  sreg;
    logic [LEN_W-1:0] cnt;

    assign tx_bit   = sreg[TX_W-1];
    assign last_bit = (cnt == LEN_W'(1));
    assign empty    = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '0;
            cnt     <= '0;
            rx_word <= '0;
        end else if (load) begin
            sreg <= load_word;
            cnt  <= load_len;
        end else if (tx_adv) begin
            sreg <= {sreg[TX_W-2:0], 1'b0};
            cnt  <= cnt - 1'b1;
        end else if (rx_adv) begin
            rx_word <= {rx_word[RX_W-2:0], rx_bit};
            cnt     <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/uw_eeprom_master.sv
`timescale 1ns/1ps
module uw_eeprom_master
    import uw_pkg::*;
#(
    parameter int PHASE_CYC = 10000,
    parameter int POLL_MAX  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

    uw_state_t st, nxt;
    uw_seg_t   seg, nxt_seg;

    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [POLL_W-1:0]    poll_cnt;
    logic                 to_flag, cs_idle;
    logic                 ph_exp, restart;
    logic                 ld, tx_adv, rx_adv, poll_inc, poll_clr, to_set;
    logic [CMD_W-1:0]     ld_word;
    logic [CMD_LEN_W-1:0] ld_len;
    logic                 tx_bit, last_bit, sh_empty;
    logic [DATA_W-1:0]    rx_word;
    logic                 accept;

    assign restart = (st == ST_IDLE) || (st == ST_FINISH);
    assign accept  = (st == ST_IDLE) && req_valid;
    assign busy    = (st != ST_IDLE);
    assign done    = (st == ST_FINISH);

    uw_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .expire(ph_exp)
    );

    uw_bit_shifter #(.TX_W(CMD_W), .RX_W(DATA_W), .LEN_W(CMD_LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_word(ld_word),
        .load_len(ld_len), .tx_adv(tx_adv), .rx_adv(rx_adv),
        .rx_bit(ee_do), .tx_bit(tx_bit), .last_bit(last_bit),
        .empty(sh_empty), .rx_word(rx_word)
    );

    // next-state and sequencing controls
    always_comb begin
        nxt      = st;
        nxt_seg  = seg;
        ld       = 1'b0;
        ld_word  = '0;
        ld_len   = '0;
        tx_adv   = 1'b0;
        rx_adv   = 1'b0;
        poll_inc = 1'b0;
        poll_clr = 1'b0;
        to_set   = 1'b0;
        unique case (st)
            ST_IDLE: if (req_valid) begin
                nxt     = ST_SETUP_LO;
                nxt_seg = req_write ? SEG_EN : SEG_RD;
            end
            ST_SETUP_LO: if (ph_exp) nxt = ST_SETUP_CS;
            ST_SETUP_CS: if (ph_exp) begin
                nxt = ST_TX_SET;
                ld  = 1'b1;
                if (seg == SEG_RD) begin
                    ld_word = {OP_READ, addr_q, {DATA_W{1'b0}}};
                    ld_len  = CMD_LEN_W'(RD_LEN);
                end else begin
                    ld_word = {OP_WEN, {(CMD_W-5){1'b0}}};
                    ld_len  = CMD_LEN_W'(CTL_LEN);
                end
            end
            ST_TX_SET: if (ph_exp) nxt = ST_TX_HI;
            ST_TX_HI:  if (ph_exp) nxt = ST_TX_LO;
            ST_TX_LO: if (ph_exp) begin
                tx_adv = 1'b1;
                nxt    = last_bit ? ST_TX_END : ST_TX_SET;
            end
            ST_TX_END: if (ph_exp) begin
                unique case (seg)
                    SEG_RD: begin
                        nxt     = ST_RX_HI;
                        ld      = 1'b1;
                        ld_len  = CMD_LEN_W'(DATA_W);
                    end
                    SEG_EN:  nxt = ST_SB_DROP;
                    SEG_WR: begin
                        nxt     = ST_SB_DROP;
                        nxt_seg = SEG_WAIT;
                    end
                    SEG_DIS: nxt = ST_CL_DROP;
                    default: nxt = ST_FINISH;
                endcase
            end
            ST_RX_HI: if (ph_exp) begin
                rx_adv = 1'b1;
                nxt    = ST_RX_LO;
            end
            ST_RX_LO: if (ph_exp) nxt = sh_empty ? ST_SB_DROP : ST_RX_HI;
            ST_SB_DROP: if (ph_exp) nxt = ST_SB_SKHI;
            ST_SB_SKHI: if (ph_exp) nxt = ST_SB_CSHI;
            ST_SB_CSHI: if (ph_exp) nxt = ST_SB_SKLO;
            ST_SB_SKLO: if (ph_exp) begin
                unique case (seg)
                    SEG_EN: begin
                        nxt     = ST_TX_SET;
                        nxt_seg = SEG_WR;
                        ld      = 1'b1;
                        ld_word = {OP_WRITE, addr_q, wdata_q};
                        ld_len  = CMD_LEN_W'(CMD_W);
                    end
                    SEG_WAIT: begin
                        nxt      = ST_POLL;
                        poll_clr = 1'b1;
                    end
                    SEG_RECOVER: begin
                        nxt     = ST_TX_SET;
                        nxt_seg = SEG_DIS;
                        ld      = 1'b1;
                        ld_word = {OP_WDIS, {(CMD_W-5){1'b0}}};
                        ld_len  = CMD_LEN_W'(CTL_LEN);
                    end
                    default: nxt = ST_FINISH;
                endcase
            end
            ST_POLL: if (ph_exp) begin
                if (ee_do) begin
                    nxt     = ST_SB_DROP;
                    nxt_seg = SEG_RECOVER;
                end else if (poll_cnt == POLL_LAST) begin
                    nxt     = ST_SB_DROP;
                    nxt_seg = SEG_RECOVER;
                    to_set  = 1'b1;
                end else begin
                    poll_inc = 1'b1;
                end
            end
            ST_CL_DROP: if (ph_exp) nxt = ST_CL_SKHI;
            ST_CL_SKHI: if (ph_exp) nxt = ST_CL_SKLO;
            ST_CL_SKLO: if (ph_exp) nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register and transaction bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            seg      <= SEG_RD;
            addr_q   <= '0;
            wdata_q  <= '0;
            poll_cnt <= '0;
            to_flag  <= 1'b0;
            cs_idle  <= 1'b0;
            rd_data  <= '0;
            timeout  <= 1'b0;
        end else begin
            st  <= nxt;
            seg <= nxt_seg;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                to_flag <= 1'b0;
                timeout <= 1'b0;
            end
            if (poll_clr)      poll_cnt <= '0;
            else if (poll_inc) poll_cnt <= poll_cnt + 1'b1;
            if (to_set) to_flag <= 1'b1;
            if (nxt == ST_FINISH && st != ST_FINISH) begin
                if (seg == SEG_RD) rd_data <= rx_word;
                timeout <= to_flag;
            end
            if (st == ST_FINISH) cs_idle <= (seg == SEG_RD);
        end
    end

    // pin levels per state
    always_comb begin
        ee_cs = 1'b1;
        ee_sk = 1'b0;
        ee_di = 1'b0;
        unique case (st)
            ST_IDLE, ST_SETUP_LO:   ee_cs = cs_idle;
            ST_TX_SET, ST_TX_LO:    ee_di = tx_bit;
            ST_TX_HI: begin
                ee_sk = 1'b1;
                ee_di = tx_bit;
            end
            ST_RX_HI, ST_SB_CSHI:   ee_sk = 1'b1;
            ST_SB_DROP, ST_CL_DROP, ST_CL_SKLO: ee_cs = 1'b0;
            ST_SB_SKHI, ST_CL_SKHI: begin
                ee_cs = 1'b0;
                ee_sk = 1'b1;
            end
            ST_FINISH:              ee_cs = (seg == SEG_RD);
            default: ;
        endcase
    end
endmodule

// File: rtl/uw_eeprom_chk.sv
`timescale 1ns/1ps
module uw_eeprom_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        timeout,
    input logic        ee_sk,
    input logic        ee_di
);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R3
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> $stable(ee_di));

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_sk && !ee_di));

    // R8
    to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);

    // R8
    to_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout) |-> $past(req_valid && !busy));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);
endmodule

bind uw_eeprom_master uw_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .done(done), .rd_data(rd_data), .timeout(timeout),
    .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/sim_uw_eeprom_master.sv
`timescale 1ns/1ps
module sim_uw_eeprom_master;
    localparam int PH = 3;
    localparam int PM = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, timeout, ee_cs, ee_sk, ee_di;
    logic [15:0] rd_data;
    logic        ee_do = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    uw_eeprom_master #(.PHASE_CYC(PH), .POLL_MAX(PM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do)
    );

    // reference model state
    logic [2:0]  q_pin[$];
    bit          q_do[$];
    bit          q_done[$];
    string       q_tag[$];
    bit          idle_cs = 1'b0;
    logic [15:0] cur_rd = '0;
    bit          cur_to = 1'b0;
    logic [15:0] pend_rd = '0;
    bit          pend_to = 1'b0;
    bit          ign_active = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit cs, input bit sk, input bit di, input bit dv, input string tag);
        for (int i = 0; i < PH; i++) begin
            q_pin.push_back({cs, sk, di});
            q_do.push_back(dv);
            q_done.push_back(1'b0);
            q_tag.push_back(tag);
        end
    endtask

    task automatic fin(input bit cs);
        q_pin.push_back({cs, 1'b0, 1'b0});
        q_do.push_back(1'b0);
        q_done.push_back(1'b1);
        q_tag.push_back("R10");
    endtask

    task automatic send(input logic [24:0] w, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) begin
            step(1, 0, w[i], 0, tag);
            step(1, 1, w[i], 0, "R3");
            step(1, 0, w[i], 0, "R3");
        end
        step(1, 0, 0, 0, "R3");
    endtask

    task automatic standby(input string tag);
        step(0, 0, 0, 0, tag);
        step(0, 1, 0, 0, tag);
        step(1, 1, 0, 0, tag);
        step(1, 0, 0, 0, tag);
    endtask

    task automatic wait_idle;
        forever begin
            @(negedge clk); #1;
            if (q_pin.size() == 0) break;
        end
        @(negedge clk); #1;
    endtask

    task automatic do_read(input logic [5:0] a, input logic [15:0] d);
        wait_idle();
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 16'hDEAD;
        step(idle_cs, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        send({16'b0, 3'b110, a}, 9, "R4");
        for (int i = 15; i >= 0; i--) begin
            step(1, 1, 0, d[i], "R4");
            step(1, 0, 0, d[i], "R4");
        end
        standby("R5");
        fin(1);
        pend_rd = d; pend_to = 0; cur_to = 0; idle_cs = 1;
        @(negedge clk); #1;
        req_valid = 0;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d, input int bw, input bit ign);
        int n;
        wait_idle();
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        n = (bw < PM) ? bw + 1 : PM;
        step(idle_cs, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        send({5'b10011, 4'b0000, 16'b0}, 25, "R6");
        q_pin = q_pin[0 : q_pin.size() - 1 - 16 * 3 * PH - PH];
        q_do = q_do[0 : q_do.size() - 1 - 16 * 3 * PH - PH];
        q_done = q_done[0 : q_done.size() - 1 - 16 * 3 * PH - PH];
        q_tag = q_tag[0 : q_tag.size() - 1 - 16 * 3 * PH - PH];
        step(1, 0, 0, 0, "R3");
        standby("R6");
        send({3'b101, a, d}, 25, "R6");
        standby("R7");
        for (int k = 0; k < n; k++) step(1, 0, 0, (k >= bw), (bw >= PM) ? "R8" : "R7");
        standby("R9");
        send({5'b10000, 4'b0000, 16'b0}, 25, "R9");
        q_pin = q_pin[0 : q_pin.size() - 1 - 16 * 3 * PH - PH];
        q_do = q_do[0 : q_do.size() - 1 - 16 * 3 * PH - PH];
        q_done = q_done[0 : q_done.size() - 1 - 16 * 3 * PH - PH];
        q_tag = q_tag[0 : q_tag.size() - 1 - 16 * 3 * PH - PH];
        step(1, 0, 0, 0, "R3");
        step(0, 0, 0, 0, "R9");
        step(0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
        fin(0);
        pend_rd = cur_rd; pend_to = (bw >= PM); cur_to = 0; idle_cs = 0;
        @(negedge clk); #1;
        req_valid = 0;
        if (ign) begin
            repeat (40) @(negedge clk);
            #1;
            ign_active = 1; req_valid = 1; req_write = 0; req_addr = 6'h03;
            repeat (10) @(negedge clk);
            #1;
            req_valid = 0;
            repeat (PH * 3) @(negedge clk);
            #1;
            ign_active = 0;
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] ep;
            bit ed, eb, dv;
            string tg;
            if (q_pin.size() > 0) begin
                ep = q_pin.pop_front();
                dv = q_do.pop_front();
                ed = q_done.pop_front();
                tg = q_tag.pop_front();
                eb = 1;
            end else begin
                ep = {idle_cs, 2'b00};
                dv = 0; ed = 0; eb = 0; tg = "R1";
            end
            if (ign_active) tg = "R11";
            ee_do = dv;
            if (ed) begin
                cur_rd = pend_rd;
                cur_to = pend_to;
            end
            chk({ee_cs, ee_sk, ee_di} == ep, tg, "pins", {29'b0, ee_cs, ee_sk, ee_di}, {29'b0, ep});
            chk(busy == eb, "R10", "busy", {31'b0, busy}, {31'b0, eb});
            chk(done == ed, "R10", "done", {31'b0, done}, {31'b0, ed});
            chk(rd_data == cur_rd, ed ? "R4" : "R12", "rd_data", {16'b0, rd_data}, {16'b0, cur_rd});
            chk(timeout == cur_to, "R8", "timeout", {31'b0, timeout}, {31'b0, cur_to});
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1", "reset pins", {29'b0, ee_cs, ee_sk, ee_di}, 0);
        chk(!busy && !done && !timeout, "R1", "reset flags", {29'b0, busy, done, timeout}, 0);
        chk(rd_data == 16'h0, "R1", "reset rd_data", {16'b0, rd_data}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        do_read(6'h2A, 16'hA5C3);
        do_read(6'h3F, 16'h8001);
        do_write(6'h15, 16'h1234, 3, 1'b1);
        do_write(6'h00, 16'hFFFF, 0, 1'b0);
        do_write(6'h01, 16'h0F0F, PM, 1'b0);
        do_read(6'h00, 16'h7E81);
        do_write(6'h20, 16'h5A5A, 1, 1'b0);
        wait_idle();
        repeat (8) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule